// File: doc/BRIEF.md
# Ethernet PHY Basic Control and Status Registers

This block holds the two base management registers of an Ethernet PHY: a control word at address 0 and a status word at address 1. A management agent reaches both through a simple port: a write enable with address and data, and a read strobe that marks the cycle in which the status word is consumed. Read data is combinational from the address. Addresses other than 0 and 1 read as zero.

The control word carries self-clearing command bits and three fields whose power-up values come from hardware straps. It also holds mode bits that steer the rest of the PHY: loopback, isolate, power-down and collision test. A software reset runs for a programmable number of clock cycles. It restores every control field to its default and keeps the strap values captured at the last hardware reset. The status word combines fixed capability bits with three event bits that hold their value until the status word is read: link is latched low, while remote fault and jabber are latched high. The autonegotiation engine and the link detector lie outside the block and appear as plain inputs. A collision-test generator copies transmit enable onto the collision output with bounded delays.

Top module: `phy_basic_regs`

## Requirements
- R1: Writing a control word with bit 15 set starts a software reset. Bit 15 reads 1 for exactly RST_CYCLES cycles after the write edge and then 0. Control writes made while it reads 1 are ignored.
- R2: Straps are sampled on the first clock edge after rst_n rises. The control word then reads speed (bit 13), autonegotiation enable (bit 12) and duplex (bit 8) equal to the straps, with every other bit 0. A software reset restores these same captured strap values even when the strap pins have changed since.
- R3: Writing 1 to bit 9 (restart autonegotiation) while bit 12 is 1 sets it, and it then drives an_restart_req. It clears itself in the cycle after an_started is high. Writing 0 to it does not clear it. When bit 12 is 0 the bit stays 0.
- R4: When bit 12 is 1, eff_speed100 and eff_full_dup follow an_res_speed100 and an_res_full. When bit 12 is 0 they follow bits 13 and 8 (1 = 100 Mb/s, 1 = full duplex).
- R5: pwrdn_eff is the OR of control bit 11 and the inverted active-low pin pwrdn_n. A low pin also sets bit 11, which stays set until it is written to 0.
- R6: Status bit 2 is latched low. A cycle with link_ok low clears it. It returns to 1 only on a status read made while link_ok is high, so the read that follows a failure returns 0.
- R7: Status bits 4 (remote fault) and 1 (jabber) are latched high. They stay set after a one-cycle event until a status read, and a software reset clears them.
- R8: The status word reads 0x7849 when bits 5, 4, 2 and 1 are 0. Bit 5 follows an_complete directly. Writes to address 1 have no effect.
- R9: With control bit 7 set, col rises after tx_en has been high for COL_ON_CYCLES consecutive cycles. It falls after tx_en has been low for COL_OFF_CYCLES consecutive cycles. With bit 7 clear, col stays 0.
- R10: Control bits 6:0 read 0 whatever is written to them. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| strap_speed100 | input | 1 | Speed strap, sampled after reset |
| strap_an_en | input | 1 | Autonegotiation-enable strap |
| strap_full_dup | input | 1 | Duplex strap |
| reg_addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (clears latched status bits on address 1) |
| rd_data | output | 16 | Read data for reg_addr |
| pwrdn_n | input | 1 | Active-low power-down pin |
| link_ok | input | 1 | Link good from link detector |
| jabber | input | 1 | Jabber event |
| remote_fault | input | 1 | Remote fault event |
| an_complete | input | 1 | Autonegotiation done |
| an_started | input | 1 | Autonegotiation engine accepted a restart |
| an_res_speed100 | input | 1 | Negotiated speed |
| an_res_full | input | 1 | Negotiated duplex |
| tx_en | input | 1 | Transmit enable |
| col | output | 1 | Collision output (test mode) |
| pwrdn_eff | output | 1 | Effective power-down |
| eff_speed100 | output | 1 | Effective speed |
| eff_full_dup | output | 1 | Effective duplex |
| an_restart_req | output | 1 | Restart request to autonegotiation |
| loopback_en | output | 1 | Loopback mode |
| isolate_en | output | 1 | Isolate mode |
| sw_reset_active | output | 1 | Software reset interval in progress |

## Verification
The assertions check several rules on every cycle: the control word stays frozen during a software reset, the restart bit clears after an_started and needs bit 12, a low pin forces bit 11, a link drop clears the link latch, jabber holds until it is read or cleared, the capability pattern is constant, and every col edge has a matching tx_en cause. Only the bench scenarios show the exact reset length, that strap values survive a software reset, the two-read recovery of the link bit, the effective speed and duplex selection over all input combinations, and the precise col delays.

// File: rtl/phy_basic_pkg.sv
package phy_basic_pkg;

  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;
  localparam logic [15:0] STAT_CAPS = 16'h7849;

  typedef struct packed {
    logic loopback;
    logic speed100;
    logic an_en;
    logic pdown;
    logic isolate;
    logic an_restart;
    logic full_dup;
    logic col_test;
  } ctrl_t;

  function automatic ctrl_t ctrl_default(logic spd, logic an, logic dup);
    ctrl_t c;
    c = '0;
    c.speed100 = spd;
    c.an_en    = an;
    c.full_dup = dup;
    return c;
  endfunction

  function automatic logic [15:0] ctrl_word(logic busy, ctrl_t c);
    return {busy, c.loopback, c.speed100, c.an_en, c.pdown, c.isolate,
            c.an_restart, c.full_dup, c.col_test, 7'b0};
  endfunction

  function automatic ctrl_t ctrl_apply_write(ctrl_t cur, logic [15:0] d);
    ctrl_t c;
    c            = cur;
    c.loopback   = d[14];
    c.speed100   = d[13];
    c.an_en      = d[12];
    c.pdown      = d[11];
    c.isolate    = d[10];
    c.an_restart = cur.an_restart | d[9];
    c.full_dup   = d[8];
    c.col_test   = d[7];
    return c;
  endfunction

  function automatic logic [15:0] stat_word(logic anc, logic rf, logic link, logic jab);
    return STAT_CAPS | {10'b0, anc, rf, 1'b0, link, jab, 1'b0};
  endfunction

endpackage

// File: rtl/phy_basic_rst_timer.sv
module phy_basic_rst_timer #(
  parameter int CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/phy_basic_stat_latch.sv
module phy_basic_stat_latch #(
  parameter bit LATCH_HIGH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic rd,
  input  logic ev,
  output logic q
);
  logic q_nxt;

  generate
    if (LATCH_HIGH) begin : g_high
      always_comb q_nxt = rd ? ev : (q | ev);
    end else begin : g_low
      always_comb q_nxt = rd ? ev : (q & ev);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else          q <= q_nxt;
  end
endmodule

// File: rtl/phy_basic_coltest.sv
module phy_basic_coltest #(
  parameter int ON_CYCLES  = 16,
  parameter int OFF_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_en,
  input  logic tx_en,
  output logic col
);
  localparam int MAXC = (ON_CYCLES > OFF_CYCLES) ? ON_CYCLES : OFF_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYCLES - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          col_q;
  logic          hit;

  assign hit = (cnt_q == (tx_en ? ON_LAST : OFF_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= 1'b0;
      cnt_q <= '0;
    end else if (!test_en) begin
      col_q <= 1'b0;
      cnt_q <= '0;
    end else if (tx_en != col_q) begin
      if (hit) begin
        col_q <= tx_en;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign col = col_q;
endmodule

// File: rtl/phy_basic_regs.sv
module phy_basic_regs
  import phy_basic_pkg::*;
#(
  parameter int ADDR_W         = 5,
  parameter int RST_CYCLES     = 25,
  parameter int COL_ON_CYCLES  = 16,
  parameter int COL_OFF_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_speed100,
  input  logic              strap_an_en,
  input  logic              strap_full_dup,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  input  logic              rd_en,
  output logic [15:0]       rd_data,
  input  logic              pwrdn_n,
  input  logic              link_ok,
  input  logic              jabber,
  input  logic              remote_fault,
  input  logic              an_complete,
  input  logic              an_started,
  input  logic              an_res_speed100,
  input  logic              an_res_full,
  input  logic              tx_en,
  output logic              col,
  output logic              pwrdn_eff,
  output logic              eff_speed100,
  output logic              eff_full_dup,
  output logic              an_restart_req,
  output logic              loopback_en,
  output logic              isolate_en,
  output logic              sw_reset_active
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam int NLAT = 3;
  localparam logic [NLAT-1:0] LAT_HIGH = 3'b101;

  ctrl_t      ctrl_q, ctrl_nxt;
  logic [2:0] strap_q;
  logic       init_q;
  logic       ctrl_wr, rst_start, rst_busy, stat_rd, lat_clr;
  logic [NLAT-1:0] lat_ev, lat_q;
  logic       rf_lat, link_lat, jab_lat;

  assign ctrl_wr   = wr_en && (reg_addr == A_CTRL) && init_q && !rst_busy;
  assign rst_start = ctrl_wr && wr_data[15];
  assign stat_rd   = rd_en && (reg_addr == A_STAT);
  assign lat_clr   = !init_q || rst_busy || rst_start;

  phy_basic_rst_timer #(.CYCLES(RST_CYCLES)) u_rst_timer (
    .clk(clk), .rst_n(rst_n), .start(rst_start), .busy(rst_busy)
  );

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (an_started) ctrl_nxt.an_restart = 1'b0;
    if (ctrl_wr)    ctrl_nxt = ctrl_apply_write(ctrl_nxt, wr_data);
    if (!ctrl_nxt.an_en) ctrl_nxt.an_restart = 1'b0;
    if (!pwrdn_n)   ctrl_nxt.pdown = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      strap_q <= '0;
      init_q  <= 1'b0;
    end else if (!init_q) begin
      strap_q <= {strap_speed100, strap_an_en, strap_full_dup};
      ctrl_q  <= ctrl_default(strap_speed100, strap_an_en, strap_full_dup);
      init_q  <= 1'b1;
    end else if (rst_start || rst_busy) begin
      ctrl_q  <= ctrl_default(strap_q[2], strap_q[1], strap_q[0]);
    end else begin
      ctrl_q  <= ctrl_nxt;
    end
  end

  assign lat_ev = {remote_fault, link_ok, jabber};

  generate
    for (genvar i = 0; i < NLAT; i++) begin : g_lat
      phy_basic_stat_latch #(.LATCH_HIGH(LAT_HIGH[i])) u_lat (
        .clk(clk), .rst_n(rst_n), .clr(lat_clr), .rd(stat_rd),
        .ev(lat_ev[i]), .q(lat_q[i])
      );
    end
  endgenerate

  assign rf_lat   = lat_q[2];
  assign link_lat = lat_q[1];
  assign jab_lat  = lat_q[0];

  phy_basic_coltest #(.ON_CYCLES(COL_ON_CYCLES), .OFF_CYCLES(COL_OFF_CYCLES)) u_coltest (
    .clk(clk), .rst_n(rst_n), .test_en(ctrl_q.col_test), .tx_en(tx_en), .col(col)
  );

  always_comb begin
    if (reg_addr == A_CTRL)      rd_data = ctrl_word(rst_busy, ctrl_q);
    else if (reg_addr == A_STAT) rd_data = stat_word(an_complete, rf_lat, link_lat, jab_lat);
    else                         rd_data = '0;
  end

  assign pwrdn_eff       = ctrl_q.pdown | !pwrdn_n;
  assign eff_speed100    = ctrl_q.an_en ? an_res_speed100 : ctrl_q.speed100;
  assign eff_full_dup    = ctrl_q.an_en ? an_res_full     : ctrl_q.full_dup;
  assign an_restart_req  = ctrl_q.an_restart;
  assign loopback_en     = ctrl_q.loopback;
  assign isolate_en      = ctrl_q.isolate;
  assign sw_reset_active = rst_busy;
endmodule

// File: rtl/phy_basic_regs_chk.sv
module phy_basic_regs_chk
  import phy_basic_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_q,
  input logic              rst_busy,
  input ctrl_t             ctrl_q,
  input logic              an_started,
  input logic              wr_restart,
  input logic              pwrdn_n,
  input logic              pwrdn_eff,
  input logic              link_ok,
  input logic              link_lat,
  input logic              jab_lat,
  input logic              stat_rd,
  input logic              lat_clr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       rd_data,
  input logic              tx_en,
  input logic              col
);
  p_hold_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_busy && $past(rst_busy)) |-> $stable(ctrl_q));

  p_restart_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && !rst_busy && ctrl_q.an_restart && an_started && !wr_restart) |=> !ctrl_q.an_restart);

  p_restart_needs_an_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.an_restart |-> ctrl_q.an_en);

  p_pin_sets_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && !rst_busy && !pwrdn_n) |=> (ctrl_q.pdown || rst_busy));

  p_pin_forces_pd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |-> pwrdn_eff);

  p_link_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> !link_lat);

  p_jab_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (jab_lat && !stat_rd && !lat_clr) |=> jab_lat);

  p_caps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(STAT_ADDR)) |-> ((rd_data & 16'hFFC9) == STAT_CAPS));

  p_col_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col) |-> ($past(tx_en) && $past(ctrl_q.col_test)));

  p_col_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(col) |-> (!$past(tx_en) || !$past(ctrl_q.col_test)));
endmodule

bind phy_basic_regs phy_basic_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .init_q(init_q), .rst_busy(rst_busy),
  .ctrl_q(ctrl_q), .an_started(an_started), .wr_restart(ctrl_wr && wr_data[9]),
  .pwrdn_n(pwrdn_n), .pwrdn_eff(pwrdn_eff), .link_ok(link_ok),
  .link_lat(link_lat), .jab_lat(jab_lat), .stat_rd(stat_rd), .lat_clr(lat_clr),
  .reg_addr(reg_addr), .rd_data(rd_data), .tx_en(tx_en), .col(col)
);

// File: tb/phy_basic_regs_bench.sv
module phy_basic_regs_bench;
  localparam int CLK_P   = 10;
  localparam int AW      = 5;
  localparam int RST_N   = 6;
  localparam int COL_ON  = 4;
  localparam int COL_OFF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_speed100 = 0, strap_an_en = 0, strap_full_dup = 0;
  logic [AW-1:0] reg_addr = '0;
  logic wr_en = 0, rd_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic pwrdn_n = 1, link_ok = 0, jabber = 0, remote_fault = 0, an_complete = 0;
  logic an_started = 0, an_res_speed100 = 0, an_res_full = 0, tx_en = 0;
  logic col, pwrdn_eff, eff_speed100, eff_full_dup, an_restart_req;
  logic loopback_en, isolate_en, sw_reset_active;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  phy_basic_regs #(.ADDR_W(AW), .RST_CYCLES(RST_N), .COL_ON_CYCLES(COL_ON),
                   .COL_OFF_CYCLES(COL_OFF)) u_phy_basic_regs (
    .clk(clk), .rst_n(rst_n), .strap_speed100(strap_speed100),
    .strap_an_en(strap_an_en), .strap_full_dup(strap_full_dup),
    .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .pwrdn_n(pwrdn_n), .link_ok(link_ok), .jabber(jabber),
    .remote_fault(remote_fault), .an_complete(an_complete),
    .an_started(an_started), .an_res_speed100(an_res_speed100),
    .an_res_full(an_res_full), .tx_en(tx_en), .col(col), .pwrdn_eff(pwrdn_eff),
    .eff_speed100(eff_speed100), .eff_full_dup(eff_full_dup),
    .an_restart_req(an_restart_req), .loopback_en(loopback_en),
    .isolate_en(isolate_en), .sw_reset_active(sw_reset_active)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hard_reset(input logic s, input logic a, input logic d);
    @(negedge clk);
    rst_n = 0;
    strap_speed100 = s; strap_an_en = a; strap_full_dup = d;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input logic [15:0] data);
    reg_addr = AW'(addr); wr_data = data; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int addr, output logic [15:0] data);
    reg_addr = AW'(addr); rd_en = 1;
    #1 data = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  function automatic logic [15:0] peek(input int addr);
    reg_addr = AW'(addr);
    return rd_data;
  endfunction

  task automatic peek_chk(input string req, input int addr, input logic [15:0] exp);
    reg_addr = AW'(addr);
    #1 chk(req, rd_data, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    // Reset state while rst_n is low: control word zero
    repeat (2) @(negedge clk);
    peek_chk("R2 reset state", 0, 16'h0000);

    // R2: strap sweep
    for (int k = 0; k < 8; k++) begin
      hard_reset(k[2], k[1], k[0]);
      peek_chk("R2 strap", 0, {2'b0, k[2], k[1], 3'b0, k[0], 8'h00});
      chk("R4 strap eff speed", {15'b0, eff_speed100}, {15'b0, k[1] ? 1'b0 : k[2]});
      chk("R4 strap eff duplex", {15'b0, eff_full_dup}, {15'b0, k[1] ? 1'b0 : k[0]});
    end
    peek_chk("R8 status base", 1, 16'h7849);

    // R4: effective speed/duplex sweep
    hard_reset(0, 0, 0);
    for (int m = 0; m < 32; m++) begin
      an_res_speed100 = m[1]; an_res_full = m[0];
      wr(0, {2'b0, m[3], m[4], 3'b0, m[2], 8'h00});
      #1;
      chk("R4 eff speed", {15'b0, eff_speed100}, {15'b0, m[4] ? m[1] : m[3]});
      chk("R4 eff duplex", {15'b0, eff_full_dup}, {15'b0, m[4] ? m[0] : m[2]});
    end
    an_res_speed100 = 0; an_res_full = 0;

    // R10 / R8: reserved and write-ignored
    wr(0, 16'h007F);
    peek_chk("R10 reserved ctrl bits", 0, 16'h0000);
    wr(1, 16'hFFFF);
    peek_chk("R8 status write ignored", 1, 16'h7849);
    peek_chk("R10 unmapped addr", 5, 16'h0000);
    peek_chk("R10 unmapped addr", 31, 16'h0000);

    // R3: restart autonegotiation
    wr(0, 16'h1000);
    wr(0, 16'h1200);
    peek_chk("R3 restart set", 0, 16'h1200);
    chk("R3 restart req", {15'b0, an_restart_req}, 16'h0001);
    wr(0, 16'h1000);
    peek_chk("R3 clear by write ignored", 0, 16'h1200);
    an_started = 1;
    @(negedge clk);
    an_started = 0;
    peek_chk("R3 self clear", 0, 16'h1000);
    wr(0, 16'h0200);
    peek_chk("R3 ignored when an off", 0, 16'h0000);
    chk("R3 no req", {15'b0, an_restart_req}, 16'h0000);

    // R5: power down
    pwrdn_n = 0;
    #1 chk("R5 pin forces pd", {15'b0, pwrdn_eff}, 16'h0001);
    @(negedge clk);
    pwrdn_n = 1;
    peek_chk("R5 pin sets bit 11", 0, 16'h0800);
    chk("R5 pd held", {15'b0, pwrdn_eff}, 16'h0001);
    wr(0, 16'h0000);
    #1 chk("R5 pd cleared", {15'b0, pwrdn_eff}, 16'h0000);
    wr(0, 16'h0800);
    #1 chk("R5 bit forces pd", {15'b0, pwrdn_eff}, 16'h0001);
    wr(0, 16'h0000);

    // R6: link latched low
    link_ok = 1;
    @(negedge clk);
    rd(1, v); chk("R6 first read after up", v, 16'h7849);
    rd(1, v); chk("R6 second read", v, 16'h784D);
    link_ok = 0; @(negedge clk); link_ok = 1; @(negedge clk);
    rd(1, v); chk("R6 drop latched", v, 16'h7849);
    rd(1, v); chk("R6 recovered", v, 16'h784D);

    // R7: latched high
    jabber = 1; @(negedge clk); jabber = 0; @(negedge clk);
    peek_chk("R7 jabber held", 1, 16'h784F);
    rd(1, v); chk("R7 jabber read", v, 16'h784F);
    rd(1, v); chk("R7 jabber cleared", v, 16'h784D);
    remote_fault = 1; @(negedge clk); remote_fault = 0; @(negedge clk);
    rd(1, v); chk("R7 rf read", v, 16'h785D);
    rd(1, v); chk("R7 rf cleared", v, 16'h784D);
    an_complete = 1;
    peek_chk("R8 an_complete live", 1, 16'h786D);
    an_complete = 0;
    jabber = 1; @(negedge clk); jabber = 0;
    wr(0, 16'h8000);
    repeat (RST_N) @(negedge clk);
    rd(1, v); chk("R7 sw reset clears", v, 16'h7849);
    rd(1, v); chk("R6 link after sw reset", v, 16'h784D);

    // R1 / R2: software reset timing and strap retention
    hard_reset(1, 0, 1);
    strap_speed100 = 0; strap_an_en = 1; strap_full_dup = 0;
    wr(0, 16'h4C80);
    peek_chk("R1 pre reset value", 0, 16'h4C80);
    wr(0, 16'h8000);
    for (int i = 0; i < RST_N; i++) begin
      peek_chk("R1 busy readback", 0, 16'hA100);
      if (i == 1) begin wr_en = 1; wr_data = 16'h4000; end
      @(negedge clk);
      wr_en = 0;
    end
    peek_chk("R1 self cleared R2 straps kept", 0, 16'h2100);
    chk("R1 active low", {15'b0, sw_reset_active}, 16'h0000);
    chk("R1 loopback not written", {15'b0, loopback_en}, 16'h0000);

    // R9: collision test
    hard_reset(0, 0, 0);
    wr(0, 16'h0080);
    tx_en = 1;
    for (int i = 1; i <= COL_ON; i++) begin
      @(negedge clk);
      chk("R9 col rise", {15'b0, col}, {15'b0, i >= COL_ON});
    end
    tx_en = 0;
    for (int i = 1; i <= COL_OFF; i++) begin
      @(negedge clk);
      chk("R9 col fall", {15'b0, col}, {15'b0, i < COL_OFF});
    end
    tx_en = 1;
    repeat (COL_ON - 1) @(negedge clk);
    tx_en = 0;
    repeat (2) begin
      @(negedge clk);
      chk("R9 short pulse", {15'b0, col}, 16'h0000);
    end
    wr(0, 16'h0000);
    tx_en = 1;
    repeat (COL_ON + 2) @(negedge clk);
    chk("R9 test off", {15'b0, col}, 16'h0000);
    tx_en = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule